// File: doc/BRIEF.md
# Two-Slot Group Register Renamer

This block renames a group of two instructions in a single cycle. It keeps a mapping table from 32 architectural registers to 6-bit physical tags. Each slot presents a destination register, two source registers and a flag that says whether the slot writes its destination. In the same cycle the block returns a physical tag for every source, a fresh tag for the destination, and the tag that the destination held before. The table takes the new mappings at the next clock edge.

Two dependencies inside the group are resolved in the same cycle. If slot 1 reads a register that slot 0 writes, slot 1 receives slot 0's fresh tag and not the stale table entry. If both slots write the same register, each gets a distinct tag and the table keeps slot 1's tag. Fresh tags come from two free-tag inputs plus a count of how many are valid. A parameter picks the allocation policy. In the first policy, tags are separate rename buffers and go only to slots that write. In the second, tags are reorder-buffer entries and every slot in the group takes one. A flush input holds the block for that cycle. A group that needs more tags than are offered is held as a whole.

Top module: `rn_group_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i from 0 to 31.
- R2: A source naming register 0 always returns tag 0. A destination of register 0 is never entered into the table, and it counts as not writing.
- R3: When slot 0 writes register X (X not 0) and slot 1 reads X as either source, slot 1's source tag equals slot 0's fresh tag in that same cycle. All other sources return the current table entry.
- R4: When both slots write the same register, the two fresh tags differ, provided the two offered free tags differ. After the edge the table holds slot 1's tag for that register.
- R5: With ROB_MODE=0, only a writing slot takes a tag. The first taking slot, in slot order, gets free_tag0 and the second gets free_tag1. A slot that takes no tag shows new tag 0.
- R6: With ROB_MODE=1, both slots take a tag: slot 0 gets free_tag0 and slot 1 gets free_tag1. The table is still updated only for writing slots.
- R7: If the number of tags the group needs exceeds free_count, the group does not fire. free_take is 0, ren_stall is 1, and the table is unchanged.
- R8: While flush is 1, the group does not fire and the table is unchanged.
- R9: A writing slot's prev_tag is the mapping its destination held before this group. For slot 1 this includes slot 0's fresh tag when both slots write the same register. A non-writing slot shows prev_tag 0.
- R10: On a firing cycle, free_take equals the number of tags taken (0, 1 or 2). On any other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Hold the group this cycle |
| grp_valid | input | 1 | A group is presented |
| s0_wr | input | 1 | Slot 0 writes its destination |
| s0_dst | input | 5 | Slot 0 destination register |
| s0_src_a | input | 5 | Slot 0 first source |
| s0_src_b | input | 5 | Slot 0 second source |
| s1_wr | input | 1 | Slot 1 writes its destination |
| s1_dst | input | 5 | Slot 1 destination register |
| s1_src_a | input | 5 | Slot 1 first source |
| s1_src_b | input | 5 | Slot 1 second source |
| free_count | input | 2 | Number of valid free tags offered (0 to 2) |
| free_tag0 | input | 6 | First offered free tag |
| free_tag1 | input | 6 | Second offered free tag |
| ren_fire | output | 1 | The group is renamed this cycle |
| ren_stall | output | 1 | A group is presented but held |
| free_take | output | 2 | Number of offered tags taken |
| s0_tag_a | output | 6 | Slot 0 first source tag |
| s0_tag_b | output | 6 | Slot 0 second source tag |
| s0_new_tag | output | 6 | Slot 0 fresh tag |
| s0_prev_tag | output | 6 | Slot 0 destination's previous tag |
| s1_tag_a | output | 6 | Slot 1 first source tag |
| s1_tag_b | output | 6 | Slot 1 second source tag |
| s1_new_tag | output | 6 | Slot 1 fresh tag |
| s1_prev_tag | output | 6 | Slot 1 destination's previous tag |

## Verification
A corrupted table entry, or a write that lands in the table while the group is held, is not visible when it happens. It appears on the first later cycle in which any source or destination names that register, as a wrong source tag or a wrong prev_tag. The bench therefore draws registers from a narrow range, so that such errors surface within a few groups. A broken in-group bypass shows at once on slot 1's tags in the same cycle. A wrong tag count shows at once on free_take.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // A slot takes a tag when it writes, or always in reorder-buffer mode.
  function automatic logic slot_takes(input logic rob_mode, input logic writes);
    return rob_mode | writes;
  endfunction

  // Number of tags the group consumes.
  function automatic logic [1:0] group_need(input logic c0, input logic c1);
    return {1'b0, c0} + {1'b0, c1};
  endfunction

  // Forwarding select: the later slot sees the earlier slot's fresh tag.
  function automatic logic fwd_hit(input logic early_wr, input logic [7:0] early_dst,
                                   input logic [7:0] late_reg);
    return early_wr && (early_dst == late_reg);
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int AREGS = 32,
  parameter int TAG_W = 6,
  parameter int NRD   = 6,
  localparam int AW   = $clog2(AREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][TAG_W-1:0] rd_tag,
  input  logic                      we0,
  input  logic [AW-1:0]             wa0,
  input  logic [TAG_W-1:0]          wd0,
  input  logic                      we1,
  input  logic [AW-1:0]             wa1,
  input  logic [TAG_W-1:0]          wd1
);
  logic [TAG_W-1:0] map_q [AREGS];

  // Port 1 is written last so it wins when both address one entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < AREGS; i++) map_q[i] <= TAG_W'(i);
    end else begin
      if (we0) map_q[wa0] <= wd0;
      if (we1) map_q[wa1] <= wd1;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_tag[g] = (rd_addr[g] == '0) ? '0 : map_q[rd_addr[g]];
  end

  assert_no_zero_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !((we0 && wa0 == '0) || (we1 && wa1 == '0)));
endmodule

// File: rtl/rn_tag_alloc.sv
module rn_tag_alloc
  import rn_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter bit ROB_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_valid,
  input  logic             flush,
  input  logic             w0,
  input  logic             w1,
  input  logic [1:0]       avail,
  input  logic [TAG_W-1:0] ft0,
  input  logic [TAG_W-1:0] ft1,
  output logic             fire,
  output logic             stall,
  output logic [1:0]       take,
  output logic [TAG_W-1:0] t0,
  output logic [TAG_W-1:0] t1
);
  logic       c0, c1, room;
  logic [1:0] need;

  assign c0    = slot_takes(ROB_MODE, w0);
  assign c1    = slot_takes(ROB_MODE, w1);
  assign need  = group_need(c0, c1);
  assign room  = (need <= avail);
  assign fire  = grp_valid & ~flush & room;
  assign stall = grp_valid & ~fire;
  assign take  = fire ? need : 2'd0;
  assign t0    = c0 ? ft0 : '0;
  assign t1    = c1 ? (c0 ? ft1 : ft0) : '0;

  assert_flush_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fire);
  assert_no_over_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take <= avail);
  assert_idle_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> take == 2'd0);
  assert_distinct_tags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && c0 && c1 && ft0 != ft1) |-> t0 != t1);
endmodule

// File: rtl/rn_dep_fix.sv
module rn_dep_fix
  import rn_pkg::*;
#(
  parameter int AW    = 5,
  parameter int TAG_W = 6
) (
  input  logic             w0,
  input  logic [AW-1:0]    d0,
  input  logic [TAG_W-1:0] t0,
  input  logic             w1,
  input  logic [AW-1:0]    a1,
  input  logic [AW-1:0]    b1,
  input  logic [AW-1:0]    d1,
  input  logic [TAG_W-1:0] tab_a1,
  input  logic [TAG_W-1:0] tab_b1,
  input  logic [TAG_W-1:0] tab_d1,
  output logic [TAG_W-1:0] fix_a1,
  output logic [TAG_W-1:0] fix_b1,
  output logic [TAG_W-1:0] prev1
);
  logic hit_a, hit_b, hit_d;

  assign hit_a  = fwd_hit(w0, 8'(d0), 8'(a1));
  assign hit_b  = fwd_hit(w0, 8'(d0), 8'(b1));
  assign hit_d  = fwd_hit(w0, 8'(d0), 8'(d1));
  assign fix_a1 = hit_a ? t0 : tab_a1;
  assign fix_b1 = hit_b ? t0 : tab_b1;
  assign prev1  = w1 ? (hit_d ? t0 : tab_d1) : '0;
endmodule

// File: rtl/rn_group_renamer.sv
module rn_group_renamer #(
  parameter int AREGS    = 32,
  parameter int TAG_W    = 6,
  parameter bit ROB_MODE = 1'b0,
  localparam int AW      = $clog2(AREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             grp_valid,
  input  logic             s0_wr,
  input  logic [AW-1:0]    s0_dst,
  input  logic [AW-1:0]    s0_src_a,
  input  logic [AW-1:0]    s0_src_b,
  input  logic             s1_wr,
  input  logic [AW-1:0]    s1_dst,
  input  logic [AW-1:0]    s1_src_a,
  input  logic [AW-1:0]    s1_src_b,
  input  logic [1:0]       free_count,
  input  logic [TAG_W-1:0] free_tag0,
  input  logic [TAG_W-1:0] free_tag1,
  output logic             ren_fire,
  output logic             ren_stall,
  output logic [1:0]       free_take,
  output logic [TAG_W-1:0] s0_tag_a,
  output logic [TAG_W-1:0] s0_tag_b,
  output logic [TAG_W-1:0] s0_new_tag,
  output logic [TAG_W-1:0] s0_prev_tag,
  output logic [TAG_W-1:0] s1_tag_a,
  output logic [TAG_W-1:0] s1_tag_b,
  output logic [TAG_W-1:0] s1_new_tag,
  output logic [TAG_W-1:0] s1_prev_tag
);
  localparam int NRD = 6;

  // Named internal events for the assertions.
  logic                      w0_live, w1_live;
  logic [NRD-1:0][AW-1:0]    rd_addr;
  logic [NRD-1:0][TAG_W-1:0] rd_tag;
  logic [TAG_W-1:0]          t0, t1;
  logic                      commit0, commit1;

  assign w0_live = s0_wr && (s0_dst != '0);
  assign w1_live = s1_wr && (s1_dst != '0);

  assign rd_addr[0] = s0_src_a;
  assign rd_addr[1] = s0_src_b;
  assign rd_addr[2] = s0_dst;
  assign rd_addr[3] = s1_src_a;
  assign rd_addr[4] = s1_src_b;
  assign rd_addr[5] = s1_dst;

  rn_tag_alloc #(.TAG_W(TAG_W), .ROB_MODE(ROB_MODE)) u_alloc (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .flush(flush),
    .w0(w0_live), .w1(w1_live), .avail(free_count),
    .ft0(free_tag0), .ft1(free_tag1),
    .fire(ren_fire), .stall(ren_stall), .take(free_take), .t0(t0), .t1(t1)
  );

  assign commit0 = ren_fire & w0_live;
  assign commit1 = ren_fire & w1_live;

  rn_map_table #(.AREGS(AREGS), .TAG_W(TAG_W), .NRD(NRD)) u_map (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .we0(commit0), .wa0(s0_dst), .wd0(t0),
    .we1(commit1), .wa1(s1_dst), .wd1(t1)
  );

  rn_dep_fix #(.AW(AW), .TAG_W(TAG_W)) u_fix (
    .w0(w0_live), .d0(s0_dst), .t0(t0),
    .w1(w1_live), .a1(s1_src_a), .b1(s1_src_b), .d1(s1_dst),
    .tab_a1(rd_tag[3]), .tab_b1(rd_tag[4]), .tab_d1(rd_tag[5]),
    .fix_a1(s1_tag_a), .fix_b1(s1_tag_b), .prev1(s1_prev_tag)
  );

  assign s0_tag_a    = rd_tag[0];
  assign s0_tag_b    = rd_tag[1];
  assign s0_new_tag  = t0;
  assign s0_prev_tag = w0_live ? rd_tag[2] : '0;
  assign s1_new_tag  = t1;

  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_src_a == '0) |-> s0_tag_a == '0);
  assert_raw_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w0_live && s1_src_b == s0_dst) |-> s1_tag_b == s0_new_tag);
  assert_last_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit1 |=> (s0_src_a != $past(s1_dst) || s0_tag_a == $past(s1_new_tag)));
  assert_hold_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_stall && s0_src_a == s1_src_a) |=>
      (s0_src_a != $past(s0_src_a) || s0_tag_a == $past(s0_tag_a)));
endmodule

// File: tb/rn_group_renamer_test.sv
module rn_group_renamer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic flush = 0, grp_valid = 0, s0_wr = 0, s1_wr = 0;
  logic [4:0] s0_dst = 0, s0_src_a = 0, s0_src_b = 0, s1_dst = 0, s1_src_a = 0, s1_src_b = 0;
  logic [1:0] free_count = 0;
  logic [5:0] free_tag0 = 0, free_tag1 = 0;

  logic [1:0] o_fire, o_stall;
  logic [1:0] o_take [2];
  logic [5:0] o_a0 [2], o_b0 [2], o_n0 [2], o_p0 [2], o_a1 [2], o_b1 [2], o_n1 [2], o_p1 [2];

  rn_group_renamer uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
    .s0_wr(s0_wr), .s0_dst(s0_dst), .s0_src_a(s0_src_a), .s0_src_b(s0_src_b),
    .s1_wr(s1_wr), .s1_dst(s1_dst), .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
    .free_count(free_count), .free_tag0(free_tag0), .free_tag1(free_tag1),
    .ren_fire(o_fire[0]), .ren_stall(o_stall[0]), .free_take(o_take[0]),
    .s0_tag_a(o_a0[0]), .s0_tag_b(o_b0[0]), .s0_new_tag(o_n0[0]), .s0_prev_tag(o_p0[0]),
    .s1_tag_a(o_a1[0]), .s1_tag_b(o_b1[0]), .s1_new_tag(o_n1[0]), .s1_prev_tag(o_p1[0])
  );

  rn_group_renamer #(.ROB_MODE(1'b1)) uut_rob (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
    .s0_wr(s0_wr), .s0_dst(s0_dst), .s0_src_a(s0_src_a), .s0_src_b(s0_src_b),
    .s1_wr(s1_wr), .s1_dst(s1_dst), .s1_src_a(s1_src_a), .s1_src_b(s1_src_b),
    .free_count(free_count), .free_tag0(free_tag0), .free_tag1(free_tag1),
    .ren_fire(o_fire[1]), .ren_stall(o_stall[1]), .free_take(o_take[1]),
    .s0_tag_a(o_a0[1]), .s0_tag_b(o_b0[1]), .s0_new_tag(o_n0[1]), .s0_prev_tag(o_p0[1]),
    .s1_tag_a(o_a1[1]), .s1_tag_b(o_b1[1]), .s1_new_tag(o_n1[1]), .s1_prev_tag(o_p1[1])
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] mir [2][32];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] look(input int m, input logic [4:0] r);
    return (r == 0) ? 6'd0 : mir[m][r];
  endfunction

  // Present a group, check both units against the model, then advance one cycle.
  task automatic grp(input logic gv, input logic fl, input logic w0, input logic [4:0] d0,
                     input logic [4:0] a0, input logic [4:0] b0, input logic w1,
                     input logic [4:0] d1, input logic [4:0] a1, input logic [4:0] b1,
                     input logic [1:0] cnt, input logic [5:0] f0, input logic [5:0] f1);
    @(negedge clk);
    grp_valid = gv; flush = fl; s0_wr = w0; s0_dst = d0; s0_src_a = a0; s0_src_b = b0;
    s1_wr = w1; s1_dst = d1; s1_src_a = a1; s1_src_b = b1;
    free_count = cnt; free_tag0 = f0; free_tag1 = f1;
    #1;
    for (int m = 0; m < 2; m++) begin
      bit lw0, lw1, c0, c1, fire;
      int need;
      logic [5:0] e0, e1;
      lw0 = w0 && d0 != 0;
      lw1 = w1 && d1 != 0;
      c0 = (m == 1) || lw0;
      c1 = (m == 1) || lw1;
      need = int'(c0) + int'(c1);
      fire = gv && !fl && (need <= int'(cnt));
      e0 = c0 ? f0 : 6'd0;
      e1 = c1 ? (c0 ? f1 : f0) : 6'd0;
      chk(fl ? "R8 fire" : "R7 fire", int'(o_fire[m]), int'(fire));
      chk("R7 stall", int'(o_stall[m]), int'(gv && !fire));
      chk("R10 take", int'(o_take[m]), fire ? need : 0);
      chk("R2 s0 src a", int'(o_a0[m]), int'(look(m, a0)));
      chk("R2 s0 src b", int'(o_b0[m]), int'(look(m, b0)));
      chk("R3 s1 src a", int'(o_a1[m]), int'((lw0 && a1 == d0) ? e0 : look(m, a1)));
      chk("R3 s1 src b", int'(o_b1[m]), int'((lw0 && b1 == d0) ? e0 : look(m, b1)));
      chk(m == 1 ? "R6 new0" : "R5 new0", int'(o_n0[m]), int'(e0));
      chk(m == 1 ? "R6 new1" : "R5 new1", int'(o_n1[m]), int'(e1));
      chk("R9 prev0", int'(o_p0[m]), lw0 ? int'(look(m, d0)) : 0);
      chk("R9 prev1", int'(o_p1[m]), lw1 ? int'((lw0 && d1 == d0) ? e0 : look(m, d1)) : 0);
      if (fire) begin
        if (lw0) mir[m][d0] = e0;
        if (lw1) mir[m][d1] = e1;
      end
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 32; i++) mir[m][i] = 6'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity map after reset, read through idle cycles.
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      grp_valid = 0; s0_src_a = 5'(i); #1;
      chk("R1 reset map", int'(o_a0[0]), i);
      chk("R1 reset map rob", int'(o_a0[1]), i);
    end
    // R3: slot 1 reads slot 0's destination.
    grp(1, 0, 1, 5'd2, 5'd3, 5'd4, 1, 5'd5, 5'd2, 5'd2, 2'd2, 6'd33, 6'd34);
    // R4: both write register 7, then read it back.
    grp(1, 0, 1, 5'd7, 5'd1, 5'd2, 1, 5'd7, 5'd7, 5'd0, 2'd2, 6'd40, 6'd41);
    grp(0, 0, 0, 5'd0, 5'd7, 5'd7, 0, 5'd0, 5'd7, 5'd7, 2'd0, 6'd0, 6'd0);
    // R5: only slot 1 writes; it takes free_tag0.
    grp(1, 0, 0, 5'd9, 5'd1, 5'd1, 1, 5'd9, 5'd9, 5'd1, 2'd1, 6'd50, 6'd51);
    // R7: not enough tags; table must hold.
    grp(1, 0, 1, 5'd11, 5'd1, 5'd2, 1, 5'd12, 5'd3, 5'd4, 2'd1, 6'd52, 6'd53);
    grp(0, 0, 0, 5'd0, 5'd11, 5'd12, 0, 5'd0, 5'd11, 5'd12, 2'd0, 6'd0, 6'd0);
    // R8: flush holds even with tags available.
    grp(1, 1, 1, 5'd13, 5'd1, 5'd2, 0, 5'd0, 5'd13, 5'd2, 2'd2, 6'd54, 6'd55);
    grp(0, 0, 0, 5'd0, 5'd13, 5'd13, 0, 5'd0, 5'd13, 5'd13, 2'd0, 6'd0, 6'd0);
    // R2: destination 0 is not renamed.
    grp(1, 0, 1, 5'd0, 5'd0, 5'd0, 1, 5'd0, 5'd0, 5'd0, 2'd2, 6'd56, 6'd57);
    grp(1, 0, 0, 5'd0, 5'd0, 5'd0, 0, 5'd0, 5'd0, 5'd0, 2'd0, 6'd58, 6'd59);
    // Random groups over a narrow register range.
    for (int n = 0; n < 600; n++) begin
      logic [5:0] f0, f1;
      f0 = 6'($urandom_range(1, 63));
      f1 = 6'(f0 + 6'($urandom_range(1, 62)));
      grp(($urandom % 8) != 0, ($urandom % 10) == 0,
          1'($urandom), 5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
          1'($urandom), 5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
          2'($urandom % 3), f0, f1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule